// File: doc/BRIEF.md
# Runahead Mode Entry Controller

This control unit decides when a core stops waiting on a long-latency load miss at the head of its instruction window and starts pre-executing younger instructions speculatively. It also decides when the core returns to normal execution. When it enters that mode it strobes a request to checkpoint architectural register state. When the miss that blocked retirement comes back from memory, it strobes a restore and flush and then drops its mode flag.

Two efficiency filters can veto entry. The age filter rejects a miss that has already been in flight for longer than a programmable limit, because the period that follows would be too short to pay for the flush at exit. The overlap filter compares two counts: the instructions fetched in normal mode since the last exit, and the instructions pseudo-retired during the last speculative period. If fewer have been fetched than were pseudo-retired, a new period would mostly repeat work already done, so entry is rejected. A rejected attempt is flagged on a separate output so that it can be counted.

The controller is a four-state machine:
- NORMAL: the core executes normally.
- ENTER: a one-cycle state that raises the checkpoint strobe.
- RUN: the core pre-executes speculatively.
- EXIT: a one-cycle state that raises the restore strobe.

It has these transitions:
- NORMAL→ENTER, taken when the head instruction is a blocking miss and both filters pass.
- ENTER→RUN, the normal path out of ENTER.
- ENTER→EXIT, taken when the miss returns while the machine is in ENTER.
- RUN→EXIT, taken when the miss returns.
- EXIT→NORMAL, always taken.

Top module: `runahead_entry_ctrl`

## Requirements
- R1: When the machine is in normal mode, `head_miss` is high and both filters pass, then in the next cycle `ckpt_save` and `ra_active` are both 1.
- R2: `ckpt_save` lasts exactly one cycle. `ra_active` stays 1 from that cycle until the restore cycle, and `ckpt_save` stays 0 during that time.
- R3: While `ra_active` is 1 and no restore is in progress, a cycle with `miss_return` high gives `ckpt_restore`=1 in the next cycle. This also holds when the return comes during the checkpoint cycle. `ckpt_restore` is a single-cycle pulse, and `ra_active` is 0 in the cycle after it.
- R4: Entry is rejected when `miss_age` > `age_limit`. An age equal to the limit is accepted.
- R5: Entry is rejected when the fetch count N is less than the pseudo-retire count R. It is accepted when N ≥ R.
- R6: R is cleared on the clock edge that starts a period. It counts the cycles with `pretire` high while `ra_active` is 1, and saturates at 2^CNT_W−1.
- R7: N counts the cycles with `fetch_evt` high in normal mode. It is cleared in the restore cycle and saturates at 2^CNT_W−1.
- R8: No entry starts in the restore cycle: `head_miss` during that cycle gives no `ckpt_save` in the next cycle.
- R9: `entry_blocked` is high, in the same cycle, exactly when the machine is in normal mode, `head_miss` is high and a filter rejects entry. It is 0 whenever `ra_active` is 1.
- R10: While reset is held and just after it, all outputs are 0 and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_miss | input | 1 | Oldest window entry is an outstanding L2 miss blocking retirement |
| miss_age | input | AGE_W | In-flight cycles of that miss |
| age_limit | input | AGE_W | Programmable age threshold (typically 400) |
| miss_return | input | 1 | Triggering miss has returned from memory |
| pretire | input | 1 | One instruction pseudo-retired this cycle |
| fetch_evt | input | 1 | One instruction fetched this cycle |
| ckpt_save | output | 1 | Checkpoint request pulse |
| ckpt_restore | output | 1 | Restore and flush pulse |
| ra_active | output | 1 | Speculative pre-execution mode flag |
| entry_blocked | output | 1 | An entry attempt was rejected by a filter |

## Verification
The entry decision is driven through several patterns:
- A fresh miss with empty counts tells a plain entry apart from a rejected one.
- Fetch counts one below and exactly equal to the pseudo-retire count separate a "less than" comparison from a "less than or equal" one.
- Ages one above and exactly at the limit do the same for the age filter.
- Periods with 300 pseudo-retires, and normal stretches with 300 fetches, show whether the counts saturate or wrap: a wrapped count would open or close the gate at a quite different fetch total.
- A miss return during the checkpoint cycle, and a head miss held during the restore cycle, exercise the exit ordering.

// File: rtl/ra_ctrl_pkg.sv
package ra_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ENTER  = 2'd1,
        ST_RUN    = 2'd2,
        ST_EXIT   = 2'd3
    } ra_state_e;
endpackage

// File: rtl/ra_sat_ctr.sv
// Saturating event counter with synchronous clear (clear wins over increment).
module ra_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc && q != MAXV) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/ra_entry_filter.sv
// Combinational efficiency filters for runahead entry.
module ra_entry_filter #(
    parameter int AGE_W = 10,
    parameter int CNT_W = 8
) (
    input  logic [AGE_W-1:0] miss_age,
    input  logic [AGE_W-1:0] age_limit,
    input  logic [CNT_W-1:0] fetched,
    input  logic [CNT_W-1:0] retired,
    output logic             age_ok,
    output logic             overlap_ok
);
    always_comb begin
        age_ok     = (miss_age <= age_limit);
        overlap_ok = (fetched >= retired);
    end
endmodule

// File: rtl/runahead_entry_ctrl.sv
module runahead_entry_ctrl #(
    parameter int AGE_W = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_miss,
    input  logic [AGE_W-1:0] miss_age,
    input  logic [AGE_W-1:0] age_limit,
    input  logic             miss_return,
    input  logic             pretire,
    input  logic             fetch_evt,
    output logic             ckpt_save,
    output logic             ckpt_restore,
    output logic             ra_active,
    output logic             entry_blocked
);
    import ra_ctrl_pkg::*;

    ra_state_e        state_q, state_d;
    logic [CNT_W-1:0] ret_cnt, fet_cnt;
    logic             age_ok, overlap_ok;
    logic             go_enter;
    logic             ret_clr, ret_inc, fet_clr, fet_inc;

    ra_entry_filter #(.AGE_W(AGE_W), .CNT_W(CNT_W)) u_filter (
        .miss_age   (miss_age),
        .age_limit  (age_limit),
        .fetched    (fet_cnt),
        .retired    (ret_cnt),
        .age_ok     (age_ok),
        .overlap_ok (overlap_ok)
    );

    assign go_enter = head_miss && age_ok && overlap_ok;

    // Pseudo-retire count: cleared when a period starts, counts while speculative.
    assign ret_clr = (state_q == ST_NORMAL) && go_enter;
    assign ret_inc = pretire && (state_q != ST_NORMAL);

    // Fetch count: counts in normal mode, cleared in the restore cycle.
    assign fet_clr = (state_q == ST_EXIT);
    assign fet_inc = fetch_evt && (state_q == ST_NORMAL);

    ra_sat_ctr #(.W(CNT_W)) u_ret_ctr (
        .clk (clk), .rst_n (rst_n), .clr (ret_clr), .inc (ret_inc), .q (ret_cnt)
    );

    ra_sat_ctr #(.W(CNT_W)) u_fet_ctr (
        .clk (clk), .rst_n (rst_n), .clr (fet_clr), .inc (fet_inc), .q (fet_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: if (go_enter)    state_d = ST_ENTER;
            ST_ENTER:  state_d = miss_return ? ST_EXIT : ST_RUN;
            ST_RUN:    if (miss_return) state_d = ST_EXIT;
            ST_EXIT:   state_d = ST_NORMAL;
            default:   state_d = ST_NORMAL;
        endcase
    end

    // Output decode
    always_comb begin
        ckpt_save     = 1'b0;
        ckpt_restore  = 1'b0;
        ra_active     = 1'b0;
        entry_blocked = 1'b0;
        unique case (state_q)
            ST_NORMAL: entry_blocked = head_miss && !(age_ok && overlap_ok);
            ST_ENTER:  begin ckpt_save = 1'b1;    ra_active = 1'b1; end
            ST_RUN:    ra_active = 1'b1;
            ST_EXIT:   begin ckpt_restore = 1'b1; ra_active = 1'b1; end
            default:   ra_active = 1'b0;
        endcase
    end
endmodule

// File: rtl/runahead_entry_ctrl_chk.sv
module runahead_entry_ctrl_chk #(
    parameter int AGE_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             head_miss,
    input logic [AGE_W-1:0] miss_age,
    input logic [AGE_W-1:0] age_limit,
    input logic             miss_return,
    input logic             ckpt_save,
    input logic             ckpt_restore,
    input logic             ra_active,
    input logic             entry_blocked
);
    // R1: a checkpoint follows a cycle with a blocking head miss
    p_save_needs_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |-> $past(head_miss));

    // R2: checkpoint is a single pulse inside the active window
    p_save_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |=> (!ckpt_save && ra_active));

    // R3: return while active leads to restore next cycle
    p_return_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_active && !ckpt_restore && miss_return) |=> ckpt_restore);

    // R3: restore is one cycle and the flag drops after it
    p_restore_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |=> (!ckpt_restore && !ra_active));

    // R4: an accepted entry saw an age within the limit
    p_age_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |-> ($past(miss_age) <= $past(age_limit)));

    // R4: an over-age miss in normal mode is reported as blocked
    p_age_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_active && head_miss && (miss_age > age_limit)) |-> entry_blocked);

    // R8: no entry right after the restore cycle
    p_no_reentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |=> !ckpt_save);

    // R9: blocked indication never while active
    p_blocked_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ra_active |-> !entry_blocked);

    // R2: the two strobes never coincide
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ckpt_save, ckpt_restore}));
endmodule

bind runahead_entry_ctrl runahead_entry_ctrl_chk #(.AGE_W(AGE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .head_miss     (head_miss),
    .miss_age      (miss_age),
    .age_limit     (age_limit),
    .miss_return   (miss_return),
    .ckpt_save     (ckpt_save),
    .ckpt_restore  (ckpt_restore),
    .ra_active     (ra_active),
    .entry_blocked (entry_blocked)
);

// File: tb/tb_runahead_entry_ctrl.sv
`timescale 1ns/1ps
module tb_runahead_entry_ctrl;
    localparam int AGE_W = 10;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             head_miss = 1'b0;
    logic [AGE_W-1:0] miss_age = '0;
    logic [AGE_W-1:0] age_limit = 10'd400;
    logic             miss_return = 1'b0;
    logic             pretire = 1'b0;
    logic             fetch_evt = 1'b0;
    logic             ckpt_save, ckpt_restore, ra_active, entry_blocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    runahead_entry_ctrl #(.AGE_W(AGE_W), .CNT_W(CNT_W)) dut (
        .clk (clk), .rst_n (rst_n), .head_miss (head_miss), .miss_age (miss_age),
        .age_limit (age_limit), .miss_return (miss_return), .pretire (pretire),
        .fetch_evt (fetch_evt), .ckpt_save (ckpt_save), .ckpt_restore (ckpt_restore),
        .ra_active (ra_active), .entry_blocked (entry_blocked)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_fetch(input int n);
        fetch_evt = 1'b1;
        repeat (n) @(negedge clk);
        fetch_evt = 1'b0;
    endtask

    // Present a head miss for one cycle and check whether entry starts.
    task automatic try_enter(input int age, input bit exp_ok, input string req);
        head_miss = 1'b1;
        miss_age  = AGE_W'(age);
        #1;
        chk(req, "entry_blocked", int'(entry_blocked), int'(!exp_ok));
        @(negedge clk);
        head_miss = 1'b0;
        chk(req, "ckpt_save", int'(ckpt_save), int'(exp_ok));
        chk(req, "ra_active", int'(ra_active), int'(exp_ok));
    endtask

    // From the checkpoint cycle: run npr pseudo-retires, then return the miss.
    task automatic run_period(input int npr);
        head_miss = 1'b1;
        miss_age  = 10'd1000;
        #1;
        chk("R9", "entry_blocked while active", int'(entry_blocked), 0);
        head_miss = 1'b0;
        miss_age  = '0;
        if (npr > 0) begin
            pretire = 1'b1;
            repeat (npr) @(negedge clk);
            pretire = 1'b0;
        end else begin
            @(negedge clk);
        end
        chk("R2", "ckpt_save in run", int'(ckpt_save), 0);
        chk("R2", "ra_active in run", int'(ra_active), 1);
        miss_return = 1'b1;
        @(negedge clk);
        miss_return = 1'b0;
        chk("R3", "ckpt_restore", int'(ckpt_restore), 1);
        head_miss = 1'b1;          // probe for R8
        miss_age  = '0;
        @(negedge clk);
        head_miss = 1'b0;
        chk("R8", "ckpt_save after restore", int'(ckpt_save), 0);
        chk("R3", "ckpt_restore pulse", int'(ckpt_restore), 0);
        chk("R3", "ra_active after restore", int'(ra_active), 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", "ckpt_save in reset", int'(ckpt_save), 0);
        chk("R10", "ra_active in reset", int'(ra_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ckpt_restore", int'(ckpt_restore), 0);
        chk("R10", "entry_blocked", int'(entry_blocked), 0);

        // R1: plain entry with empty counts; R is 5 afterwards
        try_enter(10, 1'b1, "R1");
        run_period(5);

        // R5: N=4 < R=5 rejects, N=5 accepts
        do_fetch(4);
        try_enter(10, 1'b0, "R5");
        do_fetch(1);
        try_enter(10, 1'b1, "R5");
        run_period(0);

        // R4: age above limit rejects, age equal to limit accepts
        try_enter(401, 1'b0, "R4");
        try_enter(400, 1'b1, "R4");
        run_period(3);
        do_fetch(3);

        // R3: return during the checkpoint cycle
        try_enter(10, 1'b1, "R3");
        miss_return = 1'b1;
        @(negedge clk);
        miss_return = 1'b0;
        chk("R3", "restore after early return", int'(ckpt_restore), 1);
        @(negedge clk);
        chk("R3", "ra_active after early return", int'(ra_active), 0);

        // R6: R saturates at 255 (wrapping would give 44)
        try_enter(10, 1'b1, "R6");
        run_period(300);
        do_fetch(254);
        try_enter(10, 1'b0, "R6");
        do_fetch(1);
        try_enter(10, 1'b1, "R6");
        run_period(100);

        // R7: N saturates at 255 (wrapping 300 would give 44 < 100)
        do_fetch(300);
        try_enter(10, 1'b1, "R7");
        run_period(0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule